// File: doc/BRIEF.md
# Ring Window Shifter

The block forms a 64-bit ring from two 32-bit words and returns the 32 consecutive bits of that ring that begin at a chosen bit index. The high word always comes from a register operand. The low word comes from a second register operand or from a memory data word, chosen per operation. Operand selection, the shift and the result all happen in the same cycle. The output is combinational.

Each operation takes its shift amount from one of two places: an immediate field of the control word, or a persistent count register. That register can be loaded with an absolute count. It can also be moved by a signed delta relative to the count it holds, so that a sequence of packing or unpacking shifts can step through a word. A register update takes effect on the cycle after it is issued. A shift that reads the register in the same cycle sees the old count.

Top module: `ring_window_shifter`

## Requirements
- R1: The result bit k equals bit ((k + cnt) mod 64) of the ring {hi_word, lo_word}, where cnt is the effective count (0 to 63) and bit 0 of the ring is bit 0 of the low word.
- R2: A count of 0 returns the low word unchanged. A count of 32 returns the high word unchanged.
- R3: When src_reg is 0, the effective count is imm_cnt. When src_reg is 1, it is the value held in the count register.
- R4: When lo_is_mem is 0, the low word is reg_b. When lo_is_mem is 1, the low word is mem_data. The high word is always reg_a.
- R5: When upd_en is 1 and upd_rel is 0, the count register takes upd_val on the next clock edge.
- R6: When upd_en is 1 and upd_rel is 1, the count register takes (old + signed upd_val) mod 64 on the next clock edge, so it wraps past 63 and below 0.
- R7: A shift that reads the register in the same cycle as an update uses the old value. When upd_en is 0, the register holds its value.
- R8: Reset clears the count register to 0.
- R9: The result depends only on the present inputs and the register, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_a | input | 32 | high word of the ring |
| reg_b | input | 32 | register low-word candidate |
| mem_data | input | 32 | memory low-word candidate |
| lo_is_mem | input | 1 | picks mem_data as the low word |
| src_reg | input | 1 | takes the count from the register |
| imm_cnt | input | 6 | immediate count |
| upd_en | input | 1 | updates the count register |
| upd_rel | input | 1 | relative (1) or absolute (0) update |
| upd_val | input | 6 | new count, or signed delta |
| cnt_q | output | 6 | present count register value |
| result | output | 32 | the selected window |

## Verification
The bench sweeps all 64 counts for several operand pairs against an arithmetic rotate. This catches a shifter that pads with zeros instead of wrapping past bit 63, which would corrupt the top bits for counts above 32. Relative updates are driven across the 63 to 0 boundary in both directions; a design that saturates, or that treats the delta as unsigned, would leave the wrong count. Same-cycle update and register-sourced shifts check that the old count is used; a design that forwards the new count would return the wrong window. The low-word select and the reset value are checked directly at the ports.

// File: rtl/ring_window_shifter.sv
module ring_window_shifter #(
  parameter int W  = 32,
  parameter int CW = $clog2(2*W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  reg_a,
  input  logic [W-1:0]  reg_b,
  input  logic [W-1:0]  mem_data,
  input  logic          lo_is_mem,
  input  logic          src_reg,
  input  logic [CW-1:0] imm_cnt,
  input  logic          upd_en,
  input  logic          upd_rel,
  input  logic [CW-1:0] upd_val,
  output logic [CW-1:0] cnt_q,
  output logic [W-1:0]  result
);
  localparam int RW = 2*W;

  logic [W-1:0]  lo_word;
  logic [RW-1:0] ring;
  logic [CW-1:0] cnt;
  logic [RW-1:0] stage [CW+1];

  assign lo_word = lo_is_mem ? mem_data : reg_b;
  assign ring    = {reg_a, lo_word};
  assign cnt     = src_reg ? cnt_q : imm_cnt;

  assign stage[0] = ring;
  for (genvar s = 0; s < CW; s++) begin : g_rot
    localparam int D = 1 << s;
    assign stage[s+1] = cnt[s] ? {stage[s][D-1:0], stage[s][RW-1:D]} : stage[s];
  end
  assign result = stage[CW][W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (upd_en) cnt_q <= upd_rel ? cnt_q + upd_val : upd_val;
  end

  AST_CNT_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_reg && imm_cnt == '0) |-> result == lo_word); // R2
  AST_CNT_HALF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_reg && imm_cnt == CW'(W)) |-> result == reg_a); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(cnt_q)); // R7
  AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_rel) |=> cnt_q == $past(upd_val)); // R5
  AST_REL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_rel) |=> cnt_q == CW'($past(cnt_q) + $past(upd_val))); // R6
  AST_WRAP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_reg && imm_cnt == CW'(RW-1)) |-> result[1] == reg_b[0] || lo_is_mem); // R1
endmodule

// File: tb/test_ring_window_shifter.sv
module test_ring_window_shifter;
  logic clk = 0, rst_n = 0;
  logic [31:0] reg_a = 0, reg_b = 0, mem_data = 0;
  logic lo_is_mem = 0, src_reg = 0, upd_en = 0, upd_rel = 0;
  logic [5:0] imm_cnt = 0, upd_val = 0;
  logic [5:0] cnt_q;
  logic [31:0] result;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ring_window_shifter i_ring_window_shifter (.*);

  function automatic logic [31:0] ref_win(logic [31:0] hi, logic [31:0] lo, int c);
    logic [63:0] r = {hi, lo};
    logic [31:0] w;
    for (int k = 0; k < 32; k++) w[k] = r[(k + c) % 64];
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] mdl;
    tick(); tick();
    chk("R8", 32'(cnt_q), 0);
    rst_n = 1; tick();
    for (int p = 0; p < 6; p++) begin
      reg_a = $urandom; reg_b = $urandom; mem_data = $urandom;
      if (p == 0) begin reg_a = 32'h8000_0001; reg_b = 32'h0000_0003; end
      lo_is_mem = p[0];
      for (int c = 0; c < 64; c++) begin
        imm_cnt = 6'(c); #1;
        chk("R1", result, ref_win(reg_a, lo_is_mem ? mem_data : reg_b, c));
      end
    end
    lo_is_mem = 0; imm_cnt = 0; #1; chk("R2", result, reg_b);
    imm_cnt = 32; #1; chk("R2", result, reg_a);
    lo_is_mem = 1; imm_cnt = 0; #1; chk("R4", result, mem_data);
    lo_is_mem = 0; #1; chk("R4", result, reg_b);
    reg_b = 32'h1234_5678; #1; chk("R9", result, 32'h1234_5678);
    // register path
    upd_en = 1; upd_rel = 0; upd_val = 6'd60; tick();
    upd_en = 0; chk("R5", 32'(cnt_q), 60);
    mdl = 60;
    src_reg = 1; imm_cnt = 0; #1;
    chk("R3", result, ref_win(reg_a, reg_b, 60));
    upd_en = 1; upd_rel = 1; upd_val = 6'd7; #1;
    chk("R7", result, ref_win(reg_a, reg_b, 60));
    tick(); mdl = mdl + 6'd7; upd_en = 0;
    chk("R6", 32'(cnt_q), 32'(mdl));
    upd_en = 1; upd_val = 6'h3B; tick(); mdl = mdl + 6'h3B; upd_en = 0;
    chk("R6", 32'(cnt_q), 32'(mdl));
    for (int i = 0; i < 20; i++) begin
      upd_en = 1; upd_rel = i[0]; upd_val = 6'($urandom);
      mdl = upd_rel ? mdl + upd_val : upd_val;
      tick();
      chk(upd_rel ? "R6" : "R5", 32'(cnt_q), 32'(mdl));
      chk("R3", result, ref_win(reg_a, reg_b, int'(mdl)));
    end
    upd_en = 0; upd_val = 6'd5; tick(); tick();
    chk("R7", 32'(cnt_q), 32'(mdl));
    src_reg = 0; imm_cnt = 6'd17; #1;
    chk("R3", result, ref_win(reg_a, reg_b, 17));
    rst_n = 0; tick(); rst_n = 1;
    chk("R8", 32'(cnt_q), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule